// File: doc/BRIEF.md
# Segment Address Translation Unit

This block forms linear addresses from a segment register number and an effective offset. It has two modes. In real mode the stored segment value is shifted up by four bits and a 16-bit offset is added. In protected mode a selector load fetches an 8-byte descriptor from the global or the local descriptor table over a plain read port. The decoded base, limit, granularity and privilege are kept in a hidden cache entry, one per segment register.

Later translations use only the cached copy, with no table reads. Each translation reports one result one cycle later: either a linear address with a valid strobe or one fault flag. The fault flags cover an empty or null segment, a privilege mismatch and a limit overrun. A selector that points past the end of its table raises its own flag on the load. A descriptor fetch keeps the unit busy, and requests offered during that time are dropped.

Top module: `seg_xlate_top`

## Requirements
- R1: In real mode a translation yields `lin_addr = {seg,4'h0} + offset16` as a 21-bit result, zero-extended to 32 bits. Segment FFFFH with offset FFFFH gives 10FFEFH. Real mode never raises a fault.
- R2: In real mode the offset is `(xl_off + xl_disp) mod 2^16`, with the carry dropped. Segment 4000H with F000H + 3000H gives 42000H.
- R3: Selector fields are index = bits [15:3], table = bit 2 (0 global, 1 local) and requested level = bits [1:0]. A protected load reads the low dword at `table_base + index*8` and then the high dword at that address + 4. Each read holds `mem_rd` and `mem_addr` until `mem_ack`.
- R4: If `{index,3'b111}` exceeds the selected table's 16-bit limit, `flt_tbl` pulses in the cycle after the load. No read is issued and the segment's cache entry keeps its previous contents.
- R5: A global selector with index 0 is stored as null without a read. A translation through a null entry, or through an entry never loaded in protected mode, raises `flt_null`.
- R6: Descriptor decode uses these fields. The limit is high[19:16] with low[15:0]. The base is high[31:24], high[7:0] and low[31:16], in that order. Granularity is high[23] and the descriptor level is high[14:13]. A protected address is `base + (xl_off + xl_disp) mod 2^32`.
- R7: The effective limit is the 20-bit limit when granularity is 0, and `{limit,12'hFFF}` when it is 1. An offset above the effective limit raises `flt_limit`, and an offset equal to it is valid.
- R8: A requested level numerically greater than the descriptor level raises `flt_priv`. Faults are prioritised null, then privilege, then limit.
- R9: Reloading the selector already cached in a protected entry issues no read.
- R10: `busy` is high from the cycle after a fetching load until the second read completes. Loads and translations offered while busy are ignored.
- R11: When a load and a translation on the same segment are accepted in the same cycle, the translation uses the entry as it was before that load.
- R12: A translation accepted in cycle N gives exactly one of `lin_valid`, `flt_null`, `flt_priv` or `flt_limit` in cycle N+1. None of these appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 1 selects protected mode, 0 real mode |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table limit (last byte offset) |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table limit |
| ld_valid | input | 1 | Segment load request |
| ld_seg | input | SW | Segment register number to load |
| ld_sel | input | 16 | Segment value or selector |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | SW | Segment register used for translation |
| xl_off | input | 32 | Offset component |
| xl_disp | input | 32 | Second offset component |
| mem_rd | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| lin_valid | output | 1 | Linear address valid strobe |
| lin_addr | output | 32 | Linear address |
| flt_null | output | 1 | Null or empty segment used |
| flt_tbl | output | 1 | Selector beyond table limit |
| flt_priv | output | 1 | Privilege violation |
| flt_limit | output | 1 | Offset beyond segment limit |

## Verification
Two functions can meet in one cycle. A segment load that rewrites a cache entry can coincide with a translation that reads the same entry, and the bench drives both strobes on one segment in a single cycle. It expects the address from the old segment value and then the new one on the next request. The bench also offers a translation and a second load while a fetch is in progress. It expects silence on every result output and an untouched entry for the second segment.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic [1:0]  dpl;
    logic        pv;    // entry loaded in protected mode
    logic        nul;   // null selector held
  } seg_ent_t;

  function automatic logic [31:0] eff_limit(input logic [19:0] lim, input logic gran);
    return gran ? {lim, 12'hFFF} : {12'h000, lim};
  endfunction

  function automatic logic [20:0] real_lin(input logic [15:0] seg, input logic [15:0] off);
    return {1'b0, seg, 4'h0} + {5'h00, off};
  endfunction

  function automatic seg_ent_t unpack_desc(input logic [15:0] sel, input logic [31:0] lo,
                                           input logic [31:0] hi);
    seg_ent_t e;
    e.sel  = sel;
    e.base = {hi[31:24], hi[7:0], lo[31:16]};
    e.lim  = {hi[19:16], lo[15:0]};
    e.gran = hi[23];
    e.dpl  = hi[14:13];
    e.pv   = 1'b1;
    e.nul  = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/seg_cache.sv
module seg_cache
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wr_idx,
  input  seg_ent_t      wr_ent,
  input  logic [SW-1:0] rd_a_idx,
  output seg_ent_t      rd_a,
  input  logic [SW-1:0] rd_b_idx,
  output seg_ent_t      rd_b
);
  seg_ent_t ent [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    seg_ent_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (we && wr_idx == SW'(i)) r <= wr_ent;
    end
    assign ent[i] = r;
  end

  assign rd_a = (32'(rd_a_idx) < NSEG) ? ent[rd_a_idx] : '0;
  assign rd_b = (32'(rd_b_idx) < NSEG) ? ent[rd_b_idx] : '0;
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  output logic        busy,
  output logic        done,
  output logic [31:0] lo_word
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_t;
  fst_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE;
      mem_addr <= '0;
      lo_word <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin st <= F_LO; mem_addr <= start_addr; end
        F_LO:   if (mem_ack) begin lo_word <= mem_rdata; mem_addr <= mem_addr + 32'd4; st <= F_HI; end
        F_HI:   if (mem_ack) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign busy   = (st != F_IDLE);
  assign mem_rd = busy;
  assign done   = (st == F_HI) && mem_ack;

  // R3: an outstanding read keeps its request and address
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));
  // R10: a fetch is only started from idle
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  logic        prot,
  input  seg_ent_t    ent,
  input  logic [31:0] off,
  input  logic [31:0] disp,
  output logic [31:0] lin,
  output logic        f_null,
  output logic        f_priv,
  output logic        f_limit
);
  logic [31:0] o32;
  logic [15:0] o16;

  always_comb begin
    o32 = off + disp;
    o16 = off[15:0] + disp[15:0];
    lin = '0;
    f_null = 1'b0;
    f_priv = 1'b0;
    f_limit = 1'b0;
    if (!prot) lin = {11'h000, real_lin(ent.sel, o16)};
    else if (!ent.pv || ent.nul) f_null = 1'b1;
    else if (ent.sel[1:0] > ent.dpl) f_priv = 1'b1;
    else if (o32 > eff_limit(ent.lim, ent.gran)) f_limit = 1'b1;
    else lin = ent.base + o32;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter  int NSEG = 6,
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_mode,
  input  logic [31:0]   gdt_base,
  input  logic [15:0]   gdt_limit,
  input  logic [31:0]   ldt_base,
  input  logic [15:0]   ldt_limit,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_seg,
  input  logic [15:0]   ld_sel,
  input  logic          xl_valid,
  input  logic [SW-1:0] xl_seg,
  input  logic [31:0]   xl_off,
  input  logic [31:0]   xl_disp,
  output logic          mem_rd,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          lin_valid,
  output logic [31:0]   lin_addr,
  output logic          flt_null,
  output logic          flt_tbl,
  output logic          flt_priv,
  output logic          flt_limit
);
  // named internal events
  logic        ld_go, xl_go, prot_ld;
  logic        ev_same, ev_nullsel, ev_overrun, ev_fetch, ev_tblflt, fetch_done;
  logic [12:0] ld_idx;
  logic        ld_ti;
  logic [15:0] tbl_lim;
  logic [31:0] tbl_base, lo_word;
  seg_ent_t    ent_x, ent_l, wr_ent;
  logic        we;
  logic [SW-1:0] wr_idx, pend_seg;
  logic [15:0] pend_sel;
  logic [31:0] c_lin;
  logic        c_null, c_priv, c_limit;

  assign ld_go      = ld_valid && !busy;
  assign xl_go      = xl_valid && !busy;
  assign ld_idx     = ld_sel[15:3];
  assign ld_ti      = ld_sel[2];
  assign tbl_lim    = ld_ti ? ldt_limit : gdt_limit;
  assign tbl_base   = ld_ti ? ldt_base : gdt_base;
  assign ev_same    = ent_l.pv && (ent_l.sel == ld_sel);
  assign ev_nullsel = (ld_idx == 13'd0) && !ld_ti;
  assign ev_overrun = {ld_idx, 3'b111} > tbl_lim;
  assign prot_ld    = ld_go && prot_mode && !ev_same;
  assign ev_fetch   = prot_ld && !ev_nullsel && !ev_overrun;
  assign ev_tblflt  = prot_ld && !ev_nullsel && ev_overrun;

  seg_cache #(.NSEG(NSEG), .SW(SW)) u_cache (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .rd_a_idx(xl_seg), .rd_a(ent_x), .rd_b_idx(ld_seg), .rd_b(ent_l)
  );

  seg_desc_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .start(ev_fetch),
    .start_addr(tbl_base + {16'h0000, ld_idx, 3'b000}),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .busy(busy), .done(fetch_done), .lo_word(lo_word)
  );

  seg_check u_check (
    .prot(prot_mode), .ent(ent_x), .off(xl_off), .disp(xl_disp),
    .lin(c_lin), .f_null(c_null), .f_priv(c_priv), .f_limit(c_limit)
  );

  always_comb begin
    we = 1'b0;
    wr_idx = ld_seg;
    wr_ent = '0;
    if (fetch_done) begin
      we = 1'b1;
      wr_idx = pend_seg;
      wr_ent = unpack_desc(pend_sel, lo_word, mem_rdata);
    end else if (ld_go && !prot_mode) begin
      we = 1'b1;
      wr_ent.sel = ld_sel;
    end else if (prot_ld && ev_nullsel) begin
      we = 1'b1;
      wr_ent.sel = ld_sel;
      wr_ent.pv = 1'b1;
      wr_ent.nul = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_seg <= '0;
      pend_sel <= '0;
      lin_valid <= 1'b0;
      lin_addr <= '0;
      flt_null <= 1'b0;
      flt_priv <= 1'b0;
      flt_limit <= 1'b0;
      flt_tbl <= 1'b0;
    end else begin
      if (ev_fetch) begin
        pend_seg <= ld_seg;
        pend_sel <= ld_sel;
      end
      lin_valid <= xl_go && !(c_null || c_priv || c_limit);
      lin_addr  <= xl_go ? c_lin : '0;
      flt_null  <= xl_go && c_null;
      flt_priv  <= xl_go && c_priv;
      flt_limit <= xl_go && c_limit;
      flt_tbl   <= ev_tblflt;
    end
  end

  // R12: a result only follows a request
  p_result_has_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_valid || flt_null || flt_priv || flt_limit) |-> $past(xl_valid));
  // R10: nothing is produced for requests offered while busy
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(lin_valid || flt_null || flt_priv || flt_limit || flt_tbl));
  // R4: a table overrun never starts a read
  p_tbl_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_tbl |-> !mem_rd);
  // R1: real mode is fault-free
  p_real_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!prot_mode) |-> !(flt_null || flt_priv || flt_limit || flt_tbl));
endmodule

// File: tb/sim_seg_xlate_top.sv
`timescale 1ns/1ps
module sim_seg_xlate_top;
  localparam logic [31:0] GDT_B = 32'h0000_2000;
  localparam logic [15:0] GDT_L = 16'h00FF;
  localparam logic [31:0] LDT_B = 32'h0001_0000;
  localparam logic [15:0] LDT_L = 16'h007F;

  logic clk = 0, rst_n = 0, prot = 0;
  logic ld_valid = 0, xl_valid = 0;
  logic [2:0] ld_seg = 0, xl_seg = 0;
  logic [15:0] ld_sel = 0;
  logic [31:0] xl_off = 0, xl_disp = 0;
  logic mem_rd, mem_ack = 0, busy, lin_valid, flt_null, flt_tbl, flt_priv, flt_limit;
  logic [31:0] mem_addr, mem_rdata = 0, lin_addr;

  int nchk = 0, nfail = 0, rd_cnt = 0;
  logic [31:0] rd_last = 0, rd_prev = 0;
  bit finished = 0;

  logic [15:0] sh_sel [6];
  logic sh_pv [6], sh_nul [6], sh_g [6];
  logic [31:0] sh_base [6];
  logic [19:0] sh_lim [6];
  logic [1:0] sh_dpl [6];

  always #2 clk = ~clk;

  seg_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot), .gdt_base(GDT_B), .gdt_limit(GDT_L),
    .ldt_base(LDT_B), .ldt_limit(LDT_L), .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off), .xl_disp(xl_disp),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .lin_valid(lin_valid), .lin_addr(lin_addr), .flt_null(flt_null),
    .flt_tbl(flt_tbl), .flt_priv(flt_priv), .flt_limit(flt_limit)
  );

  function automatic logic [31:0] d_base(input logic ti, input logic [12:0] idx);
    return ti ? 32'h4000_0000 + 32'(idx) * 32'h120 : 32'(idx) * 32'h0001_0010;
  endfunction
  function automatic logic [19:0] d_lim(input logic [12:0] idx);
    return 20'h00040 + 20'(idx);
  endfunction

  // table contents packed per R6 field positions
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic ti; logic [12:0] idx; logic [31:0] b; logic [19:0] l;
    ti = (a >= LDT_B);
    idx = 13'((a - (ti ? LDT_B : GDT_B)) >> 3);
    b = d_base(ti, idx);
    l = d_lim(idx);
    if (!a[2]) return {b[15:0], l[15:0]};
    return {b[31:24], idx[0], 3'b000, l[19:16], 1'b1, idx[2:1], 1'b1, 4'h2, b[23:16]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_rd && !mem_ack;
      if (mem_rd && !mem_ack) begin
        mem_rdata <= mem_word(mem_addr);
        rd_cnt <= rd_cnt + 1;
        rd_prev <= rd_last;
        rd_last <= mem_addr;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packed result {lin_valid, flt_null, flt_priv, flt_limit, lin_addr}
  function automatic logic [35:0] exp_xl(input int s, input logic [31:0] off, input logic [31:0] disp);
    logic [31:0] o, eff;
    if (!prot) return {4'b1000, 32'({sh_sel[s], 4'h0}) + ((off + disp) & 32'h0000_FFFF)};
    if (!sh_pv[s] || sh_nul[s]) return {4'b0100, 32'h0};
    if (sh_sel[s][1:0] > sh_dpl[s]) return {4'b0010, 32'h0};
    o = off + disp;
    eff = sh_g[s] ? {sh_lim[s], 12'hFFF} : {12'h0, sh_lim[s]};
    if (o > eff) return {4'b0001, 32'h0};
    return {4'b1000, sh_base[s] + o};
  endfunction

  task automatic model_load(input int s, input logic [15:0] sel, output logic tf, output int nrd);
    logic [12:0] idx; logic ti;
    idx = sel[15:3]; ti = sel[2];
    tf = 0; nrd = 0;
    if (!prot) begin sh_sel[s] = sel; sh_pv[s] = 0; sh_nul[s] = 0; end
    else if (sh_pv[s] && sh_sel[s] == sel) nrd = 0;
    else if (idx == 0 && !ti) begin sh_sel[s] = sel; sh_pv[s] = 1; sh_nul[s] = 1; end
    else if ({idx, 3'b111} > (ti ? LDT_L : GDT_L)) tf = 1;
    else begin
      sh_sel[s] = sel; sh_pv[s] = 1; sh_nul[s] = 0; nrd = 2;
      sh_base[s] = d_base(ti, idx); sh_lim[s] = d_lim(idx);
      sh_g[s] = idx[0]; sh_dpl[s] = idx[2:1];
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
  endtask

  task automatic do_load(input string req, input int s, input logic [15:0] sel);
    int c0; logic tf, etf; int enrd;
    c0 = rd_cnt;
    @(negedge clk); ld_valid = 1; ld_seg = 3'(s); ld_sel = sel;
    @(negedge clk); ld_valid = 0; tf = flt_tbl;
    wait_idle();
    model_load(s, sel, etf, enrd);
    check({req, " table fault"}, 64'(tf), 64'(etf));
    check({req, " read count"}, 64'(rd_cnt - c0), 64'(enrd));
  endtask

  task automatic do_xl(input int s, input logic [31:0] off, input logic [31:0] disp,
                       output logic [35:0] r);
    @(negedge clk); xl_valid = 1; xl_seg = 3'(s); xl_off = off; xl_disp = disp;
    @(negedge clk); xl_valid = 0;
    r = {lin_valid, flt_null, flt_priv, flt_limit, lin_addr};
  endtask

  task automatic xl_chk(input string req, input int s, input logic [31:0] off, input logic [31:0] disp);
    logic [35:0] r;
    do_xl(s, off, disp, r);
    check(req, 64'(r), 64'(exp_xl(s, off, disp)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [35:0] r;
    logic [35:0] e_old;
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin
      sh_sel[i] = 0; sh_pv[i] = 0; sh_nul[i] = 0; sh_g[i] = 0;
      sh_base[i] = 0; sh_lim[i] = 0; sh_dpl[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R12 reset outputs", 64'({busy, lin_valid, flt_null, flt_tbl, flt_priv, flt_limit, mem_rd}), 64'(0));
    rst_n = 1;

    // real mode
    do_load("R1", 1, 16'h4000);
    do_xl(1, 32'h0000_F000, 32'h0000_3000, r);
    check("R2 carry dropped", 64'(r), 64'({4'b1000, 32'h0004_2000}));
    do_load("R1", 0, 16'hFFFF);
    do_xl(0, 32'h0000_FFFF, 32'h0, r);
    check("R1 above 1M", 64'(r), 64'({4'b1000, 32'h0010_FFEF}));
    do_load("R1", 2, 16'h1201);
    xl_chk("R1 paragraph", 2, 32'h0, 32'h0);
    // R11: same-cycle load and translate on one segment
    e_old = exp_xl(2, 32'h10, 32'h0);
    @(negedge clk); ld_valid = 1; ld_seg = 3'd2; ld_sel = 16'h2000;
    xl_valid = 1; xl_seg = 3'd2; xl_off = 32'h10; xl_disp = 0;
    @(negedge clk); ld_valid = 0; xl_valid = 0;
    r = {lin_valid, flt_null, flt_priv, flt_limit, lin_addr};
    check("R11 old entry used", 64'(r), 64'(e_old));
    sh_sel[2] = 16'h2000;
    do_xl(2, 32'h10, 32'h0, r);
    check("R11 new entry after", 64'(r), 64'({4'b1000, 32'h0002_0010}));
    for (int i = 0; i < 60; i++) begin
      int s; s = int'($urandom % 6);
      if ($urandom % 2 == 0) do_load("R1 rand", s, 16'($urandom));
      else xl_chk("R2 rand", s, $urandom, $urandom);
    end

    // protected mode
    prot = 1;
    do_xl(5, 32'h0, 32'h0, r);
    check("R5 never loaded", 64'(r), 64'({4'b0100, 32'h0}));
    do_load("R5", 4, 16'h0003);
    xl_chk("R5 null access", 4, 32'h0, 32'h0);
    do_load("R3", 0, 16'h00F8);
    check("R3 low addr", 64'(rd_prev), 64'(GDT_B + 32'h0F8));
    check("R3 high addr", 64'(rd_last), 64'(GDT_B + 32'h0FC));
    xl_chk("R7 G=1 at limit", 0, 32'h0005_FFFF, 32'h0);
    do_xl(0, 32'h0006_0000, 32'h0, r);
    check("R7 G=1 over", 64'(r), 64'({4'b0001, 32'h0}));
    do_load("R4 gdt overrun", 0, 16'h0100);
    xl_chk("R4 entry kept", 0, 32'h0, 32'h0);
    do_load("R4 ldt overrun", 2, 16'h0084);
    do_load("R3 ldt", 2, 16'h007C);
    check("R3 ldt low addr", 64'(rd_prev), 64'(LDT_B + 32'h078));
    do_load("R9 same selector", 0, 16'h00F8);
    do_load("R6", 3, 16'h0020);
    xl_chk("R7 G=0 at limit", 3, 32'h40, 32'h4);
    do_xl(3, 32'h45, 32'h0, r);
    check("R7 G=0 over", 64'(r), 64'({4'b0001, 32'h0}));
    xl_chk("R6 base add", 3, 32'h12, 32'h1);
    do_load("R8", 1, 16'h0013);
    do_xl(1, 32'h1000, 32'h0, r);
    check("R8 priv over limit", 64'(r), 64'({4'b0010, 32'h0}));
    do_load("R8", 1, 16'h0011);
    xl_chk("R8 level ok", 1, 32'h0, 32'h0);
    // R10: requests while busy are ignored
    @(negedge clk); ld_valid = 1; ld_seg = 3'd5; ld_sel = 16'h0048;
    @(negedge clk); ld_valid = 1; ld_seg = 3'd3; ld_sel = 16'h0050;
    xl_valid = 1; xl_seg = 3'd0; xl_off = 0; xl_disp = 0;
    check("R10 busy", 64'(busy), 64'(1));
    @(negedge clk); ld_valid = 0; xl_valid = 0;
    check("R10 no result", 64'({lin_valid, flt_null, flt_priv, flt_limit, flt_tbl}), 64'(0));
    wait_idle();
    begin logic tf; int n; model_load(5, 16'h0048, tf, n); end
    xl_chk("R10 fetched entry", 5, 32'h4, 32'h0);
    xl_chk("R10 ignored load", 3, 32'h10, 32'h0);
    for (int i = 0; i < 300; i++) begin
      int s; s = int'($urandom % 6);
      if ($urandom % 3 == 0)
        do_load("R3 rand", s, {13'($urandom % 36), 1'($urandom), 2'($urandom)});
      else begin
        logic [31:0] eff, off;
        eff = sh_g[s] ? {sh_lim[s], 12'hFFF} : {12'h0, sh_lim[s]};
        case ($urandom % 4)
          0: off = eff;
          1: off = eff + 1;
          2: off = 0;
          default: off = $urandom % (eff + 2);
        endcase
        xl_chk("R12 rand", s, off, 32'h0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule